// File: doc/BRIEF.md
# Runtime-Writable Six-Input Truth-Table Cell

This block is a logic cell that evaluates any Boolean function of six inputs. It does so by looking up a 64-entry truth table. The select inputs address one stored bit through a multiplexer tree. No register lies on that path, so the output follows the inputs combinationally. A reset loads the table from a parameter. After that, any single entry can be overwritten through a write port that is clocked and gated by an enable.

The table is held as two 32-entry halves. Each half has its own five-input multiplexer tree, and its result is brought out. The most significant select line then chooses between the two half results to form the six-input output. The cell can therefore be used in two ways:

- as one six-input function, or
- as two independent five-input functions that share the low five select lines.

Top module: `wlut6_cell`

## Requirements
- R1: `lut6_o` equals table entry k, where k is the unsigned value of `sel_i`. Bit 5 of `sel_i` is the most significant bit and bit 0 is the least significant. The output depends only on the present inputs and the stored table, with no clock delay.
- R2: Select ordering: `sel_i`=1 reads entry 1, `sel_i`=2 reads entry 2, `sel_i`=32 reads entry 32 and `sel_i`=63 reads entry 63.
- R3: `lut5_lo_o` equals entry `sel_i[4:0]`, and `lut5_hi_o` equals entry 32+`sel_i[4:0]`. Both hold whatever the value of `sel_i[5]`.
- R4: `lut6_o` equals `lut5_hi_o` when `sel_i[5]`=1, and equals `lut5_lo_o` when `sel_i[5]`=0.
- R5: A rising `clk` edge with `rst_n`=0 loads parameter `INIT_TABLE` into the table. Bit k of the parameter becomes entry k.
- R6: A rising `clk` edge with `rst_n`=1 and `wr_en_i`=1 stores `wr_bit_i` into entry `wr_addr_i`. Bit 5 of the address selects the upper half. The new value appears at the outputs right after that edge.
- R7: A rising edge with `wr_en_i`=0 leaves all 64 entries unchanged, whatever the values on `wr_addr_i` and `wr_bit_i`.
- R8: A write changes only the addressed entry. The other 63 entries, in both halves, keep their values.
- R9: Reset takes priority over a write: an edge with `rst_n`=0 and `wr_en_i`=1 still leaves the table equal to `INIT_TABLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and reset clock |
| rst_n | input | 1 | Synchronous active-low reset that reloads the table |
| sel_i | input | 6 | Select inputs; bit 5 is the most significant |
| wr_en_i | input | 1 | Write enable, sampled at the rising edge |
| wr_addr_i | input | 6 | Entry to be written |
| wr_bit_i | input | 1 | Value to store in the addressed entry |
| lut6_o | output | 1 | Six-input function output |
| lut5_lo_o | output | 1 | Output of the lower half (entries 0 to 31) |
| lut5_hi_o | output | 1 | Output of the upper half (entries 32 to 63) |

## Verification
Read results have no latency. The bench applies a select value away from the clock edge, waits 1 ns and compares all three outputs in the same cycle.

A write or a reset is due one edge after it is presented. The bench drives these stimuli on the falling edge, so the rising edge that follows takes them. It then drops the enable on the next falling edge and only after that reads back the whole table.

Writes with the enable low, and writes during reset, are checked by sweeping all 64 entries against a model. This shows that no entry moved.

// File: rtl/wlut_pkg.sv
// Package wlut_pkg
// Purpose : shared constants and types for the writable truth-table cell.
// Assumes : nothing; it holds only types and constants.
package wlut_pkg;

    // Number of select inputs of the full cell by default.
    localparam int unsigned WLUT_IN_DEF = 6;

    // Identifies which half of the table a select or write address points at.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

endpackage

// File: rtl/wlut_half_store.sv
// Module wlut_half_store
// Purpose : holds one half of the truth table as a bank of flip-flops. The
//           bank reloads from INIT_BITS on a synchronous reset, and a single
//           addressed bit is written when the write enable is high.
// Assumes : we_i has already been gated for this half by the parent.
module wlut_half_store #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH-1:0] INIT_BITS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              din_i,
    output logic [DEPTH-1:0]  bits_o
);

    logic [DEPTH-1:0] bits_q;

    // Table update: reset reloads the contents; otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= INIT_BITS;
        end else if (we_i) begin
            bits_q[addr_i] <= din_i;
        end
    end

    assign bits_o = bits_q;

    // R6: an enabled write lands in the addressed entry.
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> bits_q[$past(addr_i)] == $past(din_i));

    // R7: with no write enable, the stored bits do not move.
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && $past(rst_n)) |=> $stable(bits_q));

    // R8: a write alters at most one entry.
    a_r8_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && $past(rst_n)) |=> $countones(bits_q ^ $past(bits_q)) <= 1);

    // R5 and R9: the cycle after reset, the contents equal the initial image.
    a_r5_reset_load: assert property (@(posedge clk)
        $past(!rst_n) |-> bits_q == INIT_BITS);

endmodule

// File: rtl/wlut_mux_tree.sv
// Module wlut_mux_tree
// Purpose : a combinational binary multiplexer tree that picks entry sel_i
//           out of data_i. The root stage uses the most significant select
//           bit.
// Assumes : data_i has exactly 2**SEL_W entries; there is no clock.
module wlut_mux_tree #(
    parameter int unsigned SEL_W = 5,
    parameter int unsigned NUM   = 1 << SEL_W
) (
    input  logic [NUM-1:0]   data_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);

    // Stage lvl holds 2**lvl values; stage SEL_W is the leaves.
    for (genvar lvl = SEL_W; lvl >= 0; lvl--) begin : g_lvl
        logic [(1<<lvl)-1:0] v;
        if (lvl == SEL_W) begin : g_leaf
            // Leaf stage: copy the stored bits in.
            assign v = data_i;
        end else begin : g_node
            for (genvar j = 0; j < (1 << lvl); j++) begin : g_pair
                // Node: choose the odd or even child with this stage's select bit.
                assign v[j] = sel_i[SEL_W-1-lvl] ? g_lvl[lvl+1].v[2*j+1]
                                                 : g_lvl[lvl+1].v[2*j];
            end
        end
    end

    assign bit_o = g_lvl[0].v[0];

endmodule

// File: rtl/wlut6_cell.sv
// Module wlut6_cell
// Purpose : a six-input lookup cell with a writable truth table. The table is
//           stored as two half banks, each read through its own five-input
//           tree, and the top select bit picks which half result drives
//           lut6_o.
// Assumes : clk is the write clock; reads need no clock.
module wlut6_cell
    import wlut_pkg::*;
#(
    parameter int unsigned NUM_IN = WLUT_IN_DEF,
    parameter logic [(1<<NUM_IN)-1:0] INIT_TABLE = 64'h6A09_E667_BB67_AE85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] sel_i,
    input  logic              wr_en_i,
    input  logic [NUM_IN-1:0] wr_addr_i,
    input  logic              wr_bit_i,
    output logic              lut6_o,
    output logic              lut5_lo_o,
    output logic              lut5_hi_o
);

    localparam int unsigned HALF_IN = NUM_IN - 1;
    localparam int unsigned HALF_N  = 1 << HALF_IN;

    logic [HALF_N-1:0] part [2];
    logic              half_bit [2];
    half_e             pick;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic we_h;
        // Route the write enable to the half named by the address MSB.
        assign we_h = wr_en_i && (wr_addr_i[NUM_IN-1] == 1'(h));

        wlut_half_store #(
            .ADDR_W   (HALF_IN),
            .DEPTH    (HALF_N),
            .INIT_BITS(INIT_TABLE[h*HALF_N +: HALF_N])
        ) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we_i  (we_h),
            .addr_i(wr_addr_i[HALF_IN-1:0]),
            .din_i (wr_bit_i),
            .bits_o(part[h])
        );

        wlut_mux_tree #(
            .SEL_W(HALF_IN),
            .NUM  (HALF_N)
        ) u_tree (
            .data_i(part[h]),
            .sel_i (sel_i[HALF_IN-1:0]),
            .bit_o (half_bit[h])
        );
    end

    // Final stage: the top select bit chooses between the two half outputs.
    always_comb begin
        pick   = half_e'(sel_i[NUM_IN-1]);
        lut6_o = (pick == HALF_HI) ? half_bit[1] : half_bit[0];
    end

    assign lut5_lo_o = half_bit[0];
    assign lut5_hi_o = half_bit[1];

    // R1: the full output matches the stored entry addressed by the selects.
    a_r1_full_read: assert property (@(posedge clk) disable iff (!rst_n)
        lut6_o == part[sel_i[NUM_IN-1]][sel_i[HALF_IN-1:0]]);

    // R3: each half output reads its own bank using only the low selects.
    a_r3_half_read: assert property (@(posedge clk) disable iff (!rst_n)
        (lut5_lo_o == part[0][sel_i[HALF_IN-1:0]]) &&
        (lut5_hi_o == part[1][sel_i[HALF_IN-1:0]]));

endmodule

// File: tb/wlut6_cell_test.sv
module wlut6_cell_test;

    localparam logic [63:0] INIT = 64'h8F3C_19E6_52B0_7DA4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] sel_i;
    logic       wr_en_i;
    logic [5:0] wr_addr_i;
    logic       wr_bit_i;
    logic       lut6_o, lut5_lo_o, lut5_hi_o;

    logic [63:0] model;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wlut6_cell #(.NUM_IN(6), .INIT_TABLE(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_bit_i(wr_bit_i),
        .lut6_o(lut6_o), .lut5_lo_o(lut5_lo_o), .lut5_hi_o(lut5_hi_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Read one entry away from the edge and compare all three outputs.
    task automatic probe(input string req, input int idx);
        sel_i = 6'(idx);
        #1;
        check(req, lut6_o, model[idx]);
        check({req, " lo"}, lut5_lo_o, model[idx % 32]);
        check({req, " hi"}, lut5_hi_o, model[32 + idx % 32]);
        check({req, " R4"}, lut6_o, idx[5] ? lut5_hi_o : lut5_lo_o);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 64; i++) probe(req, i);
    endtask

    task automatic do_write(input int addr, input logic b, input logic en);
        @(negedge clk);
        wr_addr_i = 6'(addr);
        wr_bit_i  = b;
        wr_en_i   = en;
        @(negedge clk);
        wr_en_i   = 1'b0;
        if (en && rst_n) model[addr] = b;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_bit_i = 1'b0; sel_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = INIT;
        sweep("R5 reset image");
    endtask

    task automatic t_order;
        probe("R2 sel=1", 1);
        probe("R2 sel=2", 2);
        probe("R2 sel=32", 32);
        probe("R2 sel=63", 63);
    endtask

    task automatic t_halves;
        // Vary only bit 5; half outputs must not move (R3).
        for (int i = 0; i < 32; i++) begin
            sel_i = 6'(i); #1;
            check("R3 lo top0", lut5_lo_o, model[i]);
            check("R3 hi top0", lut5_hi_o, model[32+i]);
            sel_i = 6'(i + 32); #1;
            check("R3 lo top1", lut5_lo_o, model[i]);
            check("R3 hi top1", lut5_hi_o, model[32+i]);
        end
    endtask

    task automatic t_write;
        do_write(5, ~model[5], 1'b1);
        probe("R6 write lo", 5);
        do_write(44, ~model[44], 1'b1);
        probe("R6 write hi", 44);
        do_write(0, ~model[0], 1'b1);
        do_write(63, ~model[63], 1'b1);
        sweep("R8 isolation");
        sel_i = 6'd13; #1;
        do_write(13, ~model[13], 1'b1);
        #1 check("R1 live read after write", lut6_o, model[13]);
    endtask

    task automatic t_disabled;
        for (int i = 0; i < 64; i += 7) do_write(i, ~model[i], 1'b0);
        sweep("R7 enable low");
    endtask

    task automatic t_reset_priority;
        @(negedge clk);
        rst_n = 1'b0; wr_en_i = 1'b1; wr_addr_i = 6'd9; wr_bit_i = ~INIT[9];
        @(negedge clk);
        wr_en_i = 1'b0; rst_n = 1'b1;
        model = INIT;
        sweep("R9 reset over write");
    endtask

    initial begin
        t_reset;
        t_order;
        t_halves;
        t_write;
        t_disabled;
        t_reset_priority;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule